// File: doc/BRIEF.md
# FIFO Threshold Request Generator

This block turns the occupancy counts of a serial transceiver's transmit and receive FIFOs into two request levels: one that asks for more transmit data and one that asks for received data to be collected. Both levels can drive an interrupt line or a DMA trigger. Each direction has its own 2-bit threshold code, chosen at run time. The code sets how eager the request is. A request can fire as soon as there is room or data, at the half-depth mark, or only at the extreme (an empty transmit FIFO or a full receive FIFO).

A single enable input selects between FIFO operation and single-register operation. When FIFO operation is off, the threshold codes have no effect. The transmit request then copies a one-entry "holding register empty" flag, and the receive request copies a one-entry "holding register full" flag. Code 3 is reserved in both directions. While FIFO operation is on, a reserved code in either direction raises a flag and forces both requests low. All three outputs are registered and follow their inputs with one cycle of latency.

Top module: `fifo_thr_req_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `tx_req`, `rx_req` and `code_rsvd` are all 0 after that edge.
- R2: With `fifo_on`=1 and both codes legal, transmit code 0 raises `tx_req` exactly when `tx_cnt` < DEPTH.
- R3: With `fifo_on`=1 and both codes legal, transmit code 1 raises `tx_req` exactly when DEPTH − `tx_cnt` ≥ DEPTH/2. DEPTH is even.
- R4: With `fifo_on`=1 and both codes legal, transmit code 2 raises `tx_req` exactly when `tx_cnt` = 0.
- R5: With `fifo_on`=1 and both codes legal, receive code 0 raises `rx_req` exactly when `rx_cnt` ≥ 1.
- R6: With `fifo_on`=1 and both codes legal, receive code 1 raises `rx_req` exactly when `rx_cnt` ≥ DEPTH/2.
- R7: With `fifo_on`=1 and both codes legal, receive code 2 raises `rx_req` exactly when `rx_cnt` ≥ DEPTH (the FIFO is full).
- R8: With `fifo_on`=1, a code of 3 in either direction sets `code_rsvd`=1 and holds both `tx_req` and `rx_req` at 0.
- R9: With `fifo_on`=0, `tx_req` equals `tx_hold_empty`, `rx_req` equals `rx_hold_full` and `code_rsvd` is 0, whatever the threshold codes are.
- R10: Every output reflects the inputs sampled at the previous rising edge, so each input change shows at the outputs exactly one cycle later.
- R11: A count above DEPTH is treated as a full FIFO (DEPTH entries) in every threshold comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_on | input | 1 | 1 = FIFO mode with thresholds, 0 = single-register mode |
| tx_code | input | 2 | Transmit threshold code (0 not full, 1 half free, 2 empty, 3 reserved) |
| rx_code | input | 2 | Receive threshold code (0 not empty, 1 half occupied, 2 full, 3 reserved) |
| tx_cnt | input | $clog2(DEPTH+1) | Entries in the transmit FIFO |
| rx_cnt | input | $clog2(DEPTH+1) | Entries in the receive FIFO |
| tx_hold_empty | input | 1 | Transmit holding register empty, used when fifo_on=0 |
| rx_hold_full | input | 1 | Receive holding register full, used when fifo_on=0 |
| tx_req | output | 1 | Registered transmit-ready request |
| rx_req | output | 1 | Registered receive-ready request |
| code_rsvd | output | 1 | Registered flag for a reserved threshold code |

## Verification
The assertions check on every cycle the relations that hold for any input. A full transmit FIFO never requests under code 0. A non-empty one never requests under code 2. An empty receive FIFO never requests under code 0, and under code 2 the receive request equals the full condition. A reserved code quiets both requests. Bypass mode copies the holding flags. The exact half-depth crossing points, the reset state and the handling of counts above the depth are shown only by the bench. It drives counts on both sides of each boundary, and it changes inputs back to back so that every cycle's result is compared against the inputs applied one edge before.

// File: rtl/fifo_thr_pkg.sv
package fifo_thr_pkg;

  // Threshold code meanings shared by both directions
  typedef enum logic [1:0] {
    THR_EAGER   = 2'd0,   // any room (tx) / any data (rx)
    THR_HALF    = 2'd1,   // half-depth mark
    THR_EXTREME = 2'd2,   // empty (tx) / full (rx)
    THR_RSVD    = 2'd3    // reserved
  } thr_code_e;

  typedef struct packed {
    logic tx;
    logic rx;
    logic rsvd;
  } req_bits_t;

endpackage

// File: rtl/fifo_thr_tx_eval.sv
module fifo_thr_tx_eval
  import fifo_thr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [1:0]    code,
  input  logic [CW-1:0] cnt,
  output logic          hit,
  output logic          rsvd
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_LVL = CW'(DEPTH / 2);

  logic [CW-1:0] used;
  logic [CW-1:0] free_slots;
  thr_code_e     sel;

  always_comb begin
    used       = (cnt > FULL_LVL) ? FULL_LVL : cnt;
    free_slots = FULL_LVL - used;
    sel        = thr_code_e'(code);
    hit        = 1'b0;
    rsvd       = 1'b0;
    unique case (sel)
      THR_EAGER:   hit  = (free_slots != '0);
      THR_HALF:    hit  = (free_slots >= HALF_LVL);
      THR_EXTREME: hit  = (used == '0);
      THR_RSVD:    rsvd = 1'b1;
      default:     rsvd = 1'b1;
    endcase
  end

endmodule

// File: rtl/fifo_thr_rx_eval.sv
module fifo_thr_rx_eval
  import fifo_thr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [1:0]    code,
  input  logic [CW-1:0] cnt,
  output logic          hit,
  output logic          rsvd
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_LVL = CW'(DEPTH / 2);

  logic [CW-1:0] used;
  thr_code_e     sel;

  always_comb begin
    used = (cnt > FULL_LVL) ? FULL_LVL : cnt;
    sel  = thr_code_e'(code);
    hit  = 1'b0;
    rsvd = 1'b0;
    unique case (sel)
      THR_EAGER:   hit  = (used != '0);
      THR_HALF:    hit  = (used >= HALF_LVL);
      THR_EXTREME: hit  = (used == FULL_LVL);
      THR_RSVD:    rsvd = 1'b1;
      default:     rsvd = 1'b1;
    endcase
  end

endmodule

// File: rtl/fifo_thr_out_stage.sv
module fifo_thr_out_stage
  import fifo_thr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fifo_on,
  input  logic      tx_hit,
  input  logic      rx_hit,
  input  logic      tx_bad,
  input  logic      rx_bad,
  input  logic      tx_hold_empty,
  input  logic      rx_hold_full,
  output req_bits_t q
);

  req_bits_t d;

  always_comb begin
    if (!fifo_on) begin
      d.tx   = tx_hold_empty;
      d.rx   = rx_hold_full;
      d.rsvd = 1'b0;
    end else if (tx_bad || rx_bad) begin
      d.tx   = 1'b0;
      d.rx   = 1'b0;
      d.rsvd = 1'b1;
    end else begin
      d.tx   = tx_hit;
      d.rx   = rx_hit;
      d.rsvd = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/fifo_thr_req_gen.sv
module fifo_thr_req_gen
  import fifo_thr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_on,
  input  logic [1:0]    tx_code,
  input  logic [1:0]    rx_code,
  input  logic [CW-1:0] tx_cnt,
  input  logic [CW-1:0] rx_cnt,
  input  logic          tx_hold_empty,
  input  logic          rx_hold_full,
  output logic          tx_req,
  output logic          rx_req,
  output logic          code_rsvd
);

  logic      tx_hit, tx_bad;
  logic      rx_hit, rx_bad;
  req_bits_t q;

  fifo_thr_tx_eval #(.DEPTH(DEPTH)) u_tx (
    .code (tx_code),
    .cnt  (tx_cnt),
    .hit  (tx_hit),
    .rsvd (tx_bad)
  );

  fifo_thr_rx_eval #(.DEPTH(DEPTH)) u_rx (
    .code (rx_code),
    .cnt  (rx_cnt),
    .hit  (rx_hit),
    .rsvd (rx_bad)
  );

  fifo_thr_out_stage u_out (
    .clk           (clk),
    .rst           (rst),
    .fifo_on       (fifo_on),
    .tx_hit        (tx_hit),
    .rx_hit        (rx_hit),
    .tx_bad        (tx_bad),
    .rx_bad        (rx_bad),
    .tx_hold_empty (tx_hold_empty),
    .rx_hold_full  (rx_hold_full),
    .q             (q)
  );

  assign tx_req    = q.tx;
  assign rx_req    = q.rx;
  assign code_rsvd = q.rsvd;

endmodule

// File: rtl/fifo_thr_req_chk.sv
module fifo_thr_req_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_on,
  input logic [1:0]    tx_code,
  input logic [1:0]    rx_code,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_hold_empty,
  input logic          rx_hold_full,
  input logic          tx_req,
  input logic          rx_req,
  input logic          code_rsvd
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic legal;
  assign legal = (tx_code != 2'd3) && (rx_code != 2'd3);

  // R2 and R11: a full (or over-full) transmit FIFO never requests under code 0
  assert_tx_full_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (fifo_on && legal && tx_code == 2'd0 && tx_cnt >= FULL_LVL) |=> !tx_req);

  assert_tx_nonempty_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (fifo_on && legal && tx_code == 2'd2 && tx_cnt != '0) |=> !tx_req);

  assert_rx_empty_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (fifo_on && legal && rx_code == 2'd0 && rx_cnt == '0) |=> !rx_req);

  assert_rx_full_only_R7: assert property (@(posedge clk) disable iff (rst)
    (fifo_on && legal && rx_code == 2'd2) |=> (rx_req == $past(rx_cnt >= FULL_LVL)));

  assert_rsvd_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (fifo_on && !legal) |=> (code_rsvd && !tx_req && !rx_req));

  assert_bypass_follow_R9: assert property (@(posedge clk) disable iff (rst)
    (!fifo_on) |=> (tx_req == $past(tx_hold_empty) && rx_req == $past(rx_hold_full)
                    && !code_rsvd));

endmodule

bind fifo_thr_req_gen fifo_thr_req_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .fifo_on       (fifo_on),
  .tx_code       (tx_code),
  .rx_code       (rx_code),
  .tx_cnt        (tx_cnt),
  .rx_cnt        (rx_cnt),
  .tx_hold_empty (tx_hold_empty),
  .rx_hold_full  (rx_hold_full),
  .tx_req        (tx_req),
  .rx_req        (rx_req),
  .code_rsvd     (code_rsvd)
);

// File: tb/sim_fifo_thr_req_gen.sv
`timescale 1ns/1ps
module sim_fifo_thr_req_gen;

  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fifo_on = 1'b0;
  logic [1:0]    tx_code = '0;
  logic [1:0]    rx_code = '0;
  logic [CW-1:0] tx_cnt = '0;
  logic [CW-1:0] rx_cnt = '0;
  logic          tx_hold_empty = 1'b0;
  logic          rx_hold_full = 1'b0;
  logic          tx_req, rx_req, code_rsvd;

  typedef struct {
    logic  tx;
    logic  rx;
    logic  rs;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_bad  = 0;
  bit   done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  fifo_thr_req_gen #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .fifo_on(fifo_on),
    .tx_code(tx_code), .rx_code(rx_code),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_hold_empty(tx_hold_empty), .rx_hold_full(rx_hold_full),
    .tx_req(tx_req), .rx_req(rx_req), .code_rsvd(code_rsvd)
  );

  // Reference model written from the requirement list
  function automatic exp_t model(bit r, bit en, int tc, int rc, int tcn, int rcn,
                                 bit he, bit hf, string tag);
    exp_t e;
    int   tu, ru;
    e.tag = tag;
    e.tx = 1'b0; e.rx = 1'b0; e.rs = 1'b0;
    tu = (tcn > DEPTH) ? DEPTH : tcn;
    ru = (rcn > DEPTH) ? DEPTH : rcn;
    if (r) return e;
    if (!en) begin
      e.tx = he; e.rx = hf;
      return e;
    end
    if (tc == 3 || rc == 3) begin
      e.rs = 1'b1;
      return e;
    end
    case (tc)
      0: e.tx = (tu < DEPTH);
      1: e.tx = ((DEPTH - tu) >= DEPTH / 2);
      default: e.tx = (tu == 0);
    endcase
    case (rc)
      0: e.rx = (ru >= 1);
      1: e.rx = (ru >= DEPTH / 2);
      default: e.rx = (ru >= DEPTH);
    endcase
    return e;
  endfunction

  // Driver: applies one vector at the falling edge and queues its expectation
  task automatic apply(bit r, bit en, int tc, int rc, int tcn, int rcn,
                       bit he, bit hf, string tag);
    @(negedge clk);
    rst = r; fifo_on = en;
    tx_code = 2'(tc); rx_code = 2'(rc);
    tx_cnt = CW'(tcn); rx_cnt = CW'(rcn);
    tx_hold_empty = he; rx_hold_full = hf;
    exp_q.push_back(model(r, en, tc, rc, tcn, rcn, he, hf, tag));
  endtask

  // Monitor: one edge later, the registered outputs must match (R10)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_vec++;
        if (tx_req !== e.tx || rx_req !== e.rx || code_rsvd !== e.rs) begin
          n_bad++;
          $display("FAIL %s: got tx=%b rx=%b rsvd=%b, expected tx=%b rx=%b rsvd=%b",
                   e.tag, tx_req, rx_req, code_rsvd, e.tx, e.rx, e.rs);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset clears outputs even with inputs that would request
    apply(1, 1, 0, 0, 0, 5, 1, 1, "R1 reset");
    apply(1, 0, 0, 0, 0, 0, 1, 1, "R1 reset bypass");
    // R2: transmit code 0
    apply(0, 1, 0, 0, 0, 0, 0, 0, "R2 tx empty");
    apply(0, 1, 0, 0, 15, 0, 0, 0, "R2 tx one free");
    apply(0, 1, 0, 0, 16, 0, 0, 0, "R2 tx full");
    // R11: over-range counts
    apply(0, 1, 0, 2, 20, 31, 0, 0, "R11 over-range");
    // R3: transmit code 1 around half
    apply(0, 1, 1, 0, 8, 0, 0, 0, "R3 tx half free");
    apply(0, 1, 1, 0, 9, 0, 0, 0, "R3 tx below half");
    apply(0, 1, 1, 0, 0, 0, 0, 0, "R3 tx all free");
    // R4: transmit code 2
    apply(0, 1, 2, 0, 0, 0, 0, 0, "R4 tx empty");
    apply(0, 1, 2, 0, 1, 0, 0, 0, "R4 tx one used");
    // R5: receive code 0
    apply(0, 1, 0, 0, 16, 1, 0, 0, "R5 rx one");
    apply(0, 1, 0, 0, 16, 0, 0, 0, "R5 rx none");
    // R6: receive code 1
    apply(0, 1, 0, 1, 0, 7, 0, 0, "R6 rx below half");
    apply(0, 1, 0, 1, 0, 8, 0, 0, "R6 rx at half");
    // R7: receive code 2
    apply(0, 1, 2, 2, 0, 15, 0, 0, "R7 rx almost full");
    apply(0, 1, 2, 2, 0, 16, 0, 0, "R7 rx full");
    // R8: reserved code in either direction
    apply(0, 1, 3, 0, 0, 5, 1, 1, "R8 tx reserved");
    apply(0, 1, 0, 3, 0, 5, 1, 1, "R8 rx reserved");
    apply(0, 1, 3, 3, 0, 16, 0, 0, "R8 both reserved");
    // R9: bypass ignores codes and counts
    apply(0, 0, 3, 3, 16, 0, 1, 0, "R9 bypass rsvd codes");
    apply(0, 0, 2, 2, 0, 16, 0, 1, "R9 bypass hold full");
    apply(0, 0, 0, 0, 0, 16, 0, 0, "R9 bypass both low");
    // R10: back-to-back toggling, each cycle checked against the prior edge
    for (int i = 0; i < 8; i++) begin
      apply(0, 1, 0, 0, (i % 2) * 16, (i % 2), 0, 0, "R10 toggle");
    end
    apply(0, 1, 0, 0, 3, 3, 0, 0, "R10 settle");
    // R1 again mid-run
    apply(1, 1, 0, 0, 0, 9, 1, 1, "R1 reset mid-run");
    apply(0, 1, 1, 1, 8, 8, 0, 0, "R1 after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule